// File: doc/BRIEF.md
# Tone Transceiver Status and Interrupt Register

This block holds the four status flags that a host processor polls, or is interrupted by, while a tone transceiver runs. The receive path reports three kinds of single-cycle events: a decoded code has been latched, a valid tone has appeared, and a tone has validly gone away. The transmit path reports one: the pause after a burst has ended. A level input selects burst mode. From these the block keeps a receive-full flag, a transmit-empty flag, a steering flag and an interrupt summary flag, and it drives an active-low interrupt line.

The host reaches the flags over a small asynchronous parallel bus. The bus has an active-low chip select, a read/write line, an active-high data strobe and one register-select line. All four bus inputs pass through a two-flop synchronizer with edge detection. A read-cycle state machine has three states: `RD_IDLE`, `RD_ACTIVE` and `RD_RELEASE`. It takes `RD_IDLE -> RD_ACTIVE` on a qualified strobe rise, `RD_ACTIVE -> RD_RELEASE` on the strobe fall, and `RD_RELEASE -> RD_IDLE` unconditionally. The status word is driven while the state is `RD_ACTIVE`. The clear-on-read flags drop during `RD_RELEASE`, which comes after the host has already sampled the data.

Top module: `tone_status_regs`

## Requirements
- R1: After reset the status word reads 4'b1000 (steering set, all other flags clear), `irq_n` is 1 and `bus_doe` is 0.
- R2: Status bit 2 (receive full) sets on the cycle after `ev_rx_latch` and clears at the end of a status read.
- R3: Status bit 1 (transmit empty) sets on the cycle after `ev_burst_done` when `burst_en` is 1, and clears at the end of a status read.
- R4: While `burst_en` is 0, status bit 1 is held at 0: `ev_burst_done` is ignored, and a set bit 1 clears on the cycle after `burst_en` falls.
- R5: Status bit 0 equals bit 1 OR bit 2, and `irq_n` is 0 exactly while bit 0 is 1.
- R6: Status bit 3 (steering) sets on the cycle after `ev_tone_gone` and clears on the cycle after `ev_tone_valid`. It is unchanged when both arrive together, and a status read does not affect it.
- R7: Flags clear only after the strobe's trailing edge, so the value driven during the strobe is the pre-read value. Clearing takes effect on the 4th rising clock edge after `bus_ds` falls.
- R8: A set event that coincides with the clearing cycle of a read wins, and its flag stays set.
- R9: Only a read of the status register (`bus_cs_n`=0, `bus_rw`=1, `bus_rs`=1) drives the bus or clears flags. A read with `bus_rs`=0, a write (`bus_rw`=0), or a strobe with `bus_cs_n`=1 leaves every flag unchanged and `bus_doe` at 0.
- R10: `bus_doe` rises and `bus_dout` carries the status word from the 3rd rising clock edge after `bus_ds` rises. Both stay valid until the strobe fall has been synchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_rx_latch | input | 1 | Pulse: decoded code latched into receive register |
| ev_tone_valid | input | 1 | Pulse: valid tone detected |
| ev_tone_gone | input | 1 | Pulse: valid tone absence detected |
| ev_burst_done | input | 1 | Pulse: burst pause ended, transmitter ready |
| burst_en | input | 1 | Level: burst mode enabled |
| bus_cs_n | input | 1 | Host chip select, active low (asynchronous) |
| bus_rw | input | 1 | Host direction, 1 = read (asynchronous) |
| bus_ds | input | 1 | Host data strobe, active high (asynchronous) |
| bus_rs | input | 1 | Register select, 1 = status register (asynchronous) |
| bus_dout | output | 4 | Status word: [0] irq, [1] tx empty, [2] rx full, [3] steering |
| bus_doe | output | 1 | Data bus output enable |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Event inputs are already in the core domain, so a flag, and with it `irq_n`, changes one edge after the event. The bench checks these at the falling edge that follows. Bus-driven results go through two synchronizer flops and the state register. For that reason `bus_doe` is sampled at the 3rd falling edge after the strobe rises, and a read's clear is sampled at the 4th falling edge after the strobe falls. The edges just before those points are also sampled, to show that nothing moves early. The collision case places an event exactly in the clearing cycle, three falling edges after the strobe falls.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int FLAG_W   = 4;
    localparam int BIT_IRQ  = 0;
    localparam int BIT_TXE  = 1;
    localparam int BIT_RXF  = 2;
    localparam int BIT_STR  = 3;

    localparam int BUS_W    = 4;
    localparam int BUS_CS_N = 0;
    localparam int BUS_RW   = 1;
    localparam int BUS_DS   = 2;
    localparam int BUS_RS   = 3;

    typedef enum logic [1:0] {
        RD_IDLE    = 2'd0,
        RD_ACTIVE  = 2'd1,
        RD_RELEASE = 2'd2
    } rd_state_t;

endpackage

// File: rtl/tsr_bus_sync.sv
module tsr_bus_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[LAST];
    end

    always_comb begin
        lvl  = chain[LAST];
        rise = chain[LAST] & ~prev_q;
        fall = ~chain[LAST] & prev_q;
    end

endmodule

// File: rtl/tsr_rd_fsm.sv
module tsr_rd_fsm
    import tsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe_rise,
    input  logic      strobe_fall,
    input  logic      sel_status_rd,
    output logic      drive_en,
    output logic      clr_pulse,
    output rd_state_t state_q
);
    rd_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:    if (strobe_rise && sel_status_rd) state_d = RD_ACTIVE;
            RD_ACTIVE:  if (strobe_fall)                  state_d = RD_RELEASE;
            RD_RELEASE:                                   state_d = RD_IDLE;
            default:                                      state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        drive_en  = 1'b0;
        clr_pulse = 1'b0;
        unique case (state_q)
            RD_IDLE:    ;
            RD_ACTIVE:  drive_en  = 1'b1;
            RD_RELEASE: clr_pulse = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/tsr_flags.sv
module tsr_flags
    import tsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_latch,
    input  logic              ev_tone_valid,
    input  logic              ev_tone_gone,
    input  logic              ev_burst_done,
    input  logic              burst_en,
    input  logic              clr_pulse,
    output logic [FLAG_W-1:0] flags
);
    logic txe_q, rxf_q, str_q;

    // transmit empty: forced clear outside burst mode, set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             txe_q <= 1'b0;
        else if (!burst_en)     txe_q <= 1'b0;
        else if (ev_burst_done) txe_q <= 1'b1;
        else if (clr_pulse)     txe_q <= 1'b0;
    end

    // receive full: set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           rxf_q <= 1'b0;
        else if (ev_rx_latch) rxf_q <= 1'b1;
        else if (clr_pulse)   rxf_q <= 1'b0;
    end

    // steering follows tone presence only; simultaneous events hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              str_q <= 1'b1;
        else if (ev_tone_gone && !ev_tone_valid) str_q <= 1'b1;
        else if (ev_tone_valid && !ev_tone_gone) str_q <= 1'b0;
    end

    always_comb begin
        flags          = '0;
        flags[BIT_TXE] = txe_q;
        flags[BIT_RXF] = rxf_q;
        flags[BIT_STR] = str_q;
        flags[BIT_IRQ] = txe_q | rxf_q;
    end

endmodule

// File: rtl/tone_status_regs.sv
module tone_status_regs
    import tsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_rx_latch,
    input  logic        ev_tone_valid,
    input  logic        ev_tone_gone,
    input  logic        ev_burst_done,
    input  logic        burst_en,
    input  logic        bus_cs_n,
    input  logic        bus_rw,
    input  logic        bus_ds,
    input  logic        bus_rs,
    output logic [3:0]  bus_dout,
    output logic        bus_doe,
    output logic        irq_n
);
    logic [BUS_W-1:0]  bus_raw, bus_lvl, bus_rise, bus_fall;
    logic              sel_status_rd;
    logic              drive_en;
    logic              clr_pulse;
    rd_state_t         rd_state;
    logic [FLAG_W-1:0] stat_q;

    always_comb begin
        bus_raw           = '0;
        bus_raw[BUS_CS_N] = bus_cs_n;
        bus_raw[BUS_RW]   = bus_rw;
        bus_raw[BUS_DS]   = bus_ds;
        bus_raw[BUS_RS]   = bus_rs;
    end

    tsr_bus_sync #(
        .WIDTH  (BUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_raw),
        .lvl      (bus_lvl),
        .rise     (bus_rise),
        .fall     (bus_fall)
    );

    assign sel_status_rd = !bus_lvl[BUS_CS_N] && bus_lvl[BUS_RW] && bus_lvl[BUS_RS];

    tsr_rd_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe_rise   (bus_rise[BUS_DS]),
        .strobe_fall   (bus_fall[BUS_DS]),
        .sel_status_rd (sel_status_rd),
        .drive_en      (drive_en),
        .clr_pulse     (clr_pulse),
        .state_q       (rd_state)
    );

    tsr_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_rx_latch   (ev_rx_latch),
        .ev_tone_valid (ev_tone_valid),
        .ev_tone_gone  (ev_tone_gone),
        .ev_burst_done (ev_burst_done),
        .burst_en      (burst_en),
        .clr_pulse     (clr_pulse),
        .flags         (stat_q)
    );

    always_comb begin
        bus_doe  = drive_en;
        bus_dout = drive_en ? stat_q[3:0] : 4'b0000;
        irq_n    = ~stat_q[BIT_IRQ];
    end

    // unused synchronized edges of the qualifier lines
    logic unused_edges;
    assign unused_edges = ^{bus_rise[BUS_CS_N], bus_rise[BUS_RW], bus_rise[BUS_RS],
                            bus_fall[BUS_CS_N], bus_fall[BUS_RW], bus_fall[BUS_RS],
                            bus_lvl[BUS_DS], rd_state};

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_rx_latch,
    input logic       ev_tone_valid,
    input logic       ev_tone_gone,
    input logic       ev_burst_done,
    input logic       burst_en,
    input logic       clr_pulse,
    input logic       bus_doe,
    input logic       irq_n,
    input logic [3:0] stat_q
);
    assert_rx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_latch |=> stat_q[2]);

    assert_tx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_burst_done && burst_en) |=> stat_q[1]);

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_en |=> !stat_q[1]);

    assert_irq_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(stat_q[1] || stat_q[2]));

    assert_steer_gone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tone_gone && !ev_tone_valid) |=> stat_q[3]);

    assert_steer_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tone_valid && !ev_tone_gone) |=> !stat_q[3]);

    assert_clear_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[2]) |-> $past(clr_pulse));

    assert_no_drive_while_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> !bus_doe);

endmodule

bind tone_status_regs tsr_checker u_tsr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_rx_latch   (ev_rx_latch),
    .ev_tone_valid (ev_tone_valid),
    .ev_tone_gone  (ev_tone_gone),
    .ev_burst_done (ev_burst_done),
    .burst_en      (burst_en),
    .clr_pulse     (clr_pulse),
    .bus_doe       (bus_doe),
    .irq_n         (irq_n),
    .stat_q        (stat_q)
);

// File: tb/test_tone_status_regs.sv
module test_tone_status_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_rx_latch = 1'b0, ev_tone_valid = 1'b0, ev_tone_gone = 1'b0, ev_burst_done = 1'b0;
    logic       burst_en = 1'b0;
    logic       bus_cs_n = 1'b1, bus_rw = 1'b1, bus_ds = 1'b0, bus_rs = 1'b0;
    logic [3:0] bus_dout;
    logic       bus_doe, irq_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tone_status_regs i_tone_status_regs (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_latch(ev_rx_latch), .ev_tone_valid(ev_tone_valid),
        .ev_tone_gone(ev_tone_gone), .ev_burst_done(ev_burst_done),
        .burst_en(burst_en),
        .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_ds(bus_ds), .bus_rs(bus_rs),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .irq_n(irq_n)
    );

    // fields: {burst_en, rx, tx, gone, valid, exp_irq_n, exp_word[3:0]}
    localparam logic [9:0] VEC [9] = '{
        10'b0_1_0_0_0_0_1101,   // R2 R5 receive full
        10'b1_0_1_0_0_0_1011,   // R3 transmit empty in burst mode
        10'b1_0_0_0_1_1_0000,   // R6 tone valid clears steering
        10'b1_1_1_0_0_0_0111,   // R2 R3 both
        10'b0_0_1_0_0_1_0000,   // R4 burst done ignored outside burst mode
        10'b0_0_0_1_0_1_1000,   // R6 tone gone sets steering
        10'b0_0_0_0_0_1_1000,   // R6 steering survived the previous read
        10'b1_0_1_0_1_0_0011,   // R3 R6
        10'b1_1_0_1_0_0_1101    // R2 R6
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic pulse(input logic rx, input logic tx, input logic gone, input logic valid);
        ev_rx_latch = rx; ev_burst_done = tx; ev_tone_gone = gone; ev_tone_valid = valid;
        @(negedge clk);
        ev_rx_latch = 0; ev_burst_done = 0; ev_tone_gone = 0; ev_tone_valid = 0;
    endtask

    // full bus cycle; returns data and enable sampled 3 falling edges after strobe rise
    task automatic bus_cycle(input logic cs_n, input logic rw, input logic rs,
                             output logic [3:0] data, output logic oe);
        bus_cs_n = cs_n; bus_rw = rw; bus_rs = rs; bus_ds = 1'b1;
        repeat (3) @(negedge clk);
        data = bus_dout; oe = bus_doe;
        bus_ds = 1'b0;
        repeat (5) @(negedge clk);
        bus_cs_n = 1'b1; bus_rs = 1'b0; bus_rw = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] d;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_n", {3'b0, irq_n}, 4'b0001);
        chk("R1 doe", {3'b0, bus_doe}, 4'b0000);
        bus_cycle(0, 1, 1, d, oe);
        chk("R1 word", d, 4'b1000);

        // vector table
        for (int i = 0; i < 9; i++) begin
            burst_en = VEC[i][9];
            pulse(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5]);
            chk($sformatf("R5 irq_n vec%0d", i), {3'b0, irq_n}, {3'b0, VEC[i][4]});
            bus_cycle(0, 1, 1, d, oe);
            chk($sformatf("R2/R3/R4/R6 word vec%0d", i), d, VEC[i][3:0]);
            chk($sformatf("R5 irq_n after read vec%0d", i), {3'b0, irq_n}, 4'b0001);
        end

        // R10 enable timing and R7 clear timing
        burst_en = 1'b0;
        pulse(1, 0, 0, 0);
        bus_cs_n = 0; bus_rw = 1; bus_rs = 1; bus_ds = 1;
        repeat (2) @(negedge clk);
        chk("R10 doe early", {3'b0, bus_doe}, 4'b0000);
        @(negedge clk);
        chk("R10 doe on time", {3'b0, bus_doe}, 4'b0001);
        chk("R7 pre-read word", bus_dout, 4'b1101);
        bus_ds = 0;
        repeat (3) @(negedge clk);
        chk("R7 irq before clear", {3'b0, irq_n}, 4'b0000);
        @(negedge clk);
        chk("R7 irq after clear", {3'b0, irq_n}, 4'b0001);
        repeat (2) @(negedge clk);
        bus_cs_n = 1; bus_rs = 0;
        @(negedge clk);

        // R8 set during clearing cycle wins
        pulse(1, 0, 0, 0);
        bus_cs_n = 0; bus_rw = 1; bus_rs = 1; bus_ds = 1;
        repeat (3) @(negedge clk);
        bus_ds = 0;
        repeat (3) @(negedge clk);
        pulse(1, 0, 0, 0);
        chk("R8 irq kept", {3'b0, irq_n}, 4'b0000);
        repeat (2) @(negedge clk);
        bus_cs_n = 1; bus_rs = 0;
        @(negedge clk);
        bus_cycle(0, 1, 1, d, oe);
        chk("R8 word kept", d, 4'b1101);

        // R4 burst mode drop clears transmit empty
        burst_en = 1'b1;
        pulse(0, 1, 0, 0);
        chk("R4 irq set", {3'b0, irq_n}, 4'b0000);
        burst_en = 1'b0;
        @(negedge clk);
        chk("R4 irq cleared by mode drop", {3'b0, irq_n}, 4'b0001);

        // R9 non-status accesses neither drive nor clear
        pulse(1, 0, 0, 0);
        bus_cycle(0, 1, 0, d, oe);
        chk("R9 rs=0 doe", {3'b0, oe}, 4'b0000);
        chk("R9 rs=0 irq", {3'b0, irq_n}, 4'b0000);
        bus_cycle(0, 0, 1, d, oe);
        chk("R9 write doe", {3'b0, oe}, 4'b0000);
        chk("R9 write irq", {3'b0, irq_n}, 4'b0000);
        bus_cycle(1, 1, 1, d, oe);
        chk("R9 cs high doe", {3'b0, oe}, 4'b0000);
        chk("R9 cs high irq", {3'b0, irq_n}, 4'b0000);
        bus_cycle(0, 1, 1, d, oe);
        chk("R9 word intact", d, 4'b1101);

        // R6 simultaneous tone events hold steering
        pulse(0, 0, 1, 1);
        bus_cycle(0, 1, 1, d, oe);
        chk("R6 both events hold", d, 4'b1000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule